// File: doc/BRIEF.md
# DRAM Initialization and Refresh Sequencer

This block sits on the controller side of an asynchronous DRAM that is driven by row and column strobes. It owns the two strobes whenever the memory needs housekeeping: the power-up settling pause, the train of row-strobe warm-up cycles that must follow it, periodic refreshes in column-before-row order, and entry into and exit from the memory's self refresh state. A host access arbiter asks for the bus with a request line. It may start a normal read or write only while the grant is high, and it returns the bus with a one-cycle done pulse. The busy output tells the arbiter that the sequencer holds the strobes.

Every timing value is a count of clock cycles set by a parameter, so the same RTL serves any clock rate. The sequencer also watches for long stretches with no row-strobe activity, for example while periodic refresh is switched off. When such a stretch exceeds its limit, the warm-up train is run again before the next access is granted. Refreshes issued after a self refresh exit use the same column-first order as all others, and the first of them follows one full refresh interval after the exit.

Top module: `dram_refresh_seq`

## Requirements
- R1: From the rising edge of rst_n, ras_n and cas_n stay high, busy stays high and grant stays low for PAUSE_CYC+2 clock cycles: two cycles of reset synchronization, then the power-up pause.
- R2: After the pause exactly INIT_CYCLES row-only pulses follow, each with ras_n low for T_RAS cycles while cas_n stays high, separated by T_RP cycles with both strobes high. busy stays high until T_RP cycles after the last pulse and then falls.
- R3: grant is high only while busy is low and both strobes are high. It rises one cycle after busy is low with host_req high, and falls on the cycle after host_done is sampled high.
- R4: A refresh pulls cas_n low T_CAS_LEAD cycles before ras_n falls. It then holds both low for T_RAS cycles, raises both together and keeps busy high for T_RP more cycles.
- R5: While ref_en is high and nothing holds the bus, refreshes start exactly REF_INTERVAL cycles apart.
- R6: While ref_en is low no new refresh is scheduled. Time already counted toward the next refresh is kept.
- R7: When no row strobe or grant has been seen for IDLE_LIMIT cycles, the INIT_CYCLES row-only pulses of R2 are issued again with busy high, and no grant is given until they finish. Shape timing per R2.
- R8: A high sr_req while idle starts self refresh. cas_n falls, ras_n falls T_CAS_LEAD cycles later, and both then stay low with busy high for at least T_SR cycles and for as long as sr_req remains high.
- R9: Once sr_req is low and the T_SR minimum has elapsed, both strobes go high with busy held high for T_RPS cycles. After that a request is granted at once, and the next refresh is column-first and starts REF_INTERVAL+1 cycles after busy falls.
- R10: When several needs are present while idle, the warm-up rerun is served first, then a pending refresh, then self refresh, then a host request. A refresh that falls due during a host access waits for host_done and then wins over a request that is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_en | input | 1 | Enables periodic refresh scheduling |
| host_req | input | 1 | Arbiter asks for the bus |
| host_done | input | 1 | One-cycle pulse: arbiter has finished its access |
| sr_req | input | 1 | Level: enter and remain in self refresh |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| busy | output | 1 | Sequencer owns the strobes |
| grant | output | 1 | Arbiter may run an access |

## Verification
The assertions assume that host_done is raised only while grant is high and is returned low after one cycle, and that IDLE_LIMIT is larger than REF_INTERVAL, so a running refresh schedule never looks like a stale memory. The stimulus changes inputs only on falling clock edges. It pulses host_done solely during a grant and holds each access for a bounded time. It also keeps the stretch with refresh disabled shorter than the staleness limit, except in the scenario built to reach that limit.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [3:0] {
    ST_PAUSE    = 4'd0,
    ST_INIT_RAS = 4'd1,
    ST_INIT_PRE = 4'd2,
    ST_IDLE     = 4'd3,
    ST_HOST     = 4'd4,
    ST_CBR_CAS  = 4'd5,
    ST_CBR_RAS  = 4'd6,
    ST_CBR_PRE  = 4'd7,
    ST_SR_CAS   = 4'd8,
    ST_SR_ENTER = 4'd9,
    ST_SR_HOLD  = 4'd10,
    ST_SR_EXIT  = 4'd11
  } seq_state_t;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic busy;
    logic grant;
  } strobe_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Output levels for each state; registered from the next state.
  function automatic strobe_t strobe_of(input seq_state_t s);
    strobe_t o;
    o.ras_n = !(s inside {ST_INIT_RAS, ST_CBR_RAS, ST_SR_ENTER, ST_SR_HOLD});
    o.cas_n = !(s inside {ST_CBR_CAS, ST_CBR_RAS, ST_SR_CAS, ST_SR_ENTER, ST_SR_HOLD});
    o.busy  = !(s inside {ST_IDLE, ST_HOST});
    o.grant = (s == ST_HOST);
    return o;
  endfunction

endpackage

// File: rtl/drs_timer.sv
module drs_timer #(
  parameter int TW      = 8,
  parameter int RST_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  localparam logic [TW-1:0] RST_CNT = TW'(RST_VAL);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= RST_CNT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R4: interval timing relies on a strict one-per-cycle countdown
  a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/drs_refresh_tick.sv
module drs_refresh_tick #(
  parameter int INTERVAL   = 780,
  parameter int IDLE_LIMIT = 900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic hold,
  input  logic ack,
  input  logic activity,
  output logic pending,
  output logic stale
);
  localparam int RW = $clog2(INTERVAL) + 1;
  localparam int IW = $clog2(IDLE_LIMIT + 1) + 1;
  localparam logic [RW-1:0] REF_LAST  = RW'(INTERVAL - 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_LIMIT);

  logic [RW-1:0] ref_cnt_q, ref_cnt_d;
  logic          ref_cnt_en, wrap;
  logic          pend_q, pend_d;
  logic [IW-1:0] idle_q, idle_d;
  logic          idle_en;

  // Interval counter: frozen while refresh is disabled, cleared while held.
  assign wrap       = !hold && ref_en && (ref_cnt_q == REF_LAST);
  assign ref_cnt_en = hold || ref_en;

  always_comb begin
    if (hold || wrap) ref_cnt_d = '0;
    else              ref_cnt_d = ref_cnt_q + 1'b1;
  end

  always_comb begin
    if (hold) pend_d = 1'b0;
    else      pend_d = (pend_q && !ack) || wrap;
  end

  // Quiet-time counter, saturating at the limit.
  assign idle_en = hold || activity || (idle_q != IDLE_LAST);

  always_comb begin
    if (hold || activity) idle_d = '0;
    else                  idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt_q <= '0;
      pend_q    <= 1'b0;
      idle_q    <= '0;
    end else begin
      if (ref_cnt_en) ref_cnt_q <= ref_cnt_d;
      pend_q <= pend_d;
      if (idle_en) idle_q <= idle_d;
    end
  end

  assign pending = pend_q;
  assign stale   = (idle_q >= IDLE_LAST);

  // R6: with scheduling off no refresh becomes pending
  a_r6_no_new_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en && !pending) |=> !pending);

  // R7: staleness is reached only after a cycle without activity
  a_r7_stale_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stale) |-> $past(!activity && !hold));

endmodule

// File: rtl/drs_fsm.sv
module drs_fsm
  import drs_pkg::*;
#(
  parameter int TW          = 16,
  parameter int INIT_CYCLES = 8,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 3,
  parameter int T_CAS_LEAD  = 2,
  parameter int T_SR        = 5000,
  parameter int T_RPS       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_done,
  input  logic          sr_req,
  input  logic          pending,
  input  logic          stale,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          ref_ack,
  output logic          hold,
  output logic          ras_n,
  output logic          cas_n,
  output logic          busy,
  output logic          grant
);
  localparam int CW = $clog2(INIT_CYCLES + 1) + 1;
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYCLES);
  localparam logic [TW-1:0] V_RAS  = TW'(T_RAS - 1);
  localparam logic [TW-1:0] V_RP   = TW'(T_RP - 1);
  localparam logic [TW-1:0] V_LEAD = TW'(T_CAS_LEAD - 1);
  localparam logic [TW-1:0] V_SR   = TW'(T_SR - 1);
  localparam logic [TW-1:0] V_RPS  = TW'(T_RPS - 1);

  seq_state_t    state_q, state_d;
  strobe_t       out_q, out_d;
  logic [CW-1:0] init_q, init_d;
  logic          init_en;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_ack  = 1'b0;
    init_en  = 1'b0;
    init_d   = init_q;
    unique case (state_q)
      ST_PAUSE: if (tmr_done) begin
        state_d = ST_INIT_RAS; tmr_load = 1'b1; tmr_val = V_RAS;
      end
      ST_INIT_RAS: if (tmr_done) begin
        state_d = ST_INIT_PRE; tmr_load = 1'b1; tmr_val = V_RP;
        init_en = 1'b1; init_d = init_q + 1'b1;
      end
      ST_INIT_PRE: if (tmr_done) begin
        if (init_q == INIT_LAST) begin
          state_d = ST_IDLE; init_en = 1'b1; init_d = '0;
        end else begin
          state_d = ST_INIT_RAS; tmr_load = 1'b1; tmr_val = V_RAS;
        end
      end
      ST_IDLE: begin
        if (stale) begin
          state_d = ST_INIT_RAS; tmr_load = 1'b1; tmr_val = V_RAS;
        end else if (pending) begin
          state_d = ST_CBR_CAS; tmr_load = 1'b1; tmr_val = V_LEAD;
          ref_ack = 1'b1;
        end else if (sr_req) begin
          state_d = ST_SR_CAS; tmr_load = 1'b1; tmr_val = V_LEAD;
        end else if (host_req) begin
          state_d = ST_HOST;
        end
      end
      ST_HOST: if (host_done) state_d = ST_IDLE;
      ST_CBR_CAS: if (tmr_done) begin
        state_d = ST_CBR_RAS; tmr_load = 1'b1; tmr_val = V_RAS;
      end
      ST_CBR_RAS: if (tmr_done) begin
        state_d = ST_CBR_PRE; tmr_load = 1'b1; tmr_val = V_RP;
      end
      ST_CBR_PRE: if (tmr_done) state_d = ST_IDLE;
      ST_SR_CAS: if (tmr_done) begin
        state_d = ST_SR_ENTER; tmr_load = 1'b1; tmr_val = V_SR;
      end
      ST_SR_ENTER: if (tmr_done) begin
        if (sr_req) state_d = ST_SR_HOLD;
        else begin
          state_d = ST_SR_EXIT; tmr_load = 1'b1; tmr_val = V_RPS;
        end
      end
      ST_SR_HOLD: if (!sr_req) begin
        state_d = ST_SR_EXIT; tmr_load = 1'b1; tmr_val = V_RPS;
      end
      ST_SR_EXIT: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_PAUSE;
    endcase
  end

  assign out_d = strobe_of(state_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_PAUSE;
      out_q   <= '{ras_n: 1'b1, cas_n: 1'b1, busy: 1'b1, grant: 1'b0};
      init_q  <= '0;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
      if (init_en) init_q <= init_d;
    end
  end

  assign hold  = state_q inside {ST_PAUSE, ST_INIT_RAS, ST_INIT_PRE,
                                 ST_SR_CAS, ST_SR_ENTER, ST_SR_HOLD, ST_SR_EXIT};
  assign ras_n = out_q.ras_n;
  assign cas_n = out_q.cas_n;
  assign busy  = out_q.busy;
  assign grant = out_q.grant;

  // R1: strobes idle during the settling pause
  a_r1_pause_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAUSE) |-> (ras_n && cas_n && busy && !grant));

  // R2: warm-up pulses never drive the column strobe
  a_r2_init_row_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {ST_INIT_RAS, ST_INIT_PRE}) |-> (cas_n && busy));

  // R3: the arbiter only holds a quiet bus
  a_r3_grant_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (ras_n && cas_n && !busy));

  // R4: a row fall with the column low always had the column low before it
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  // R8: self refresh keeps the row strobe low while requested
  a_r8_sr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SR_HOLD && sr_req) |=> (!ras_n && !cas_n && busy));

  // R9: exit precharge keeps both strobes high and the bus owned
  a_r9_exit_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SR_EXIT) |-> (ras_n && cas_n && busy));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import drs_pkg::*;
#(
  parameter int PAUSE_CYC    = 10000,
  parameter int INIT_CYCLES  = 8,
  parameter int T_RAS        = 4,
  parameter int T_RP         = 3,
  parameter int T_CAS_LEAD   = 2,
  parameter int REF_INTERVAL = 780,
  parameter int IDLE_LIMIT   = 900,
  parameter int T_SR         = 5000,
  parameter int T_RPS        = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic host_req,
  input  logic host_done,
  input  logic sr_req,
  output logic ras_n,
  output logic cas_n,
  output logic busy,
  output logic grant
);
  localparam int MAXT = max2(max2(PAUSE_CYC, T_SR),
                             max2(max2(T_RAS, T_RP), max2(T_CAS_LEAD, T_RPS)));
  localparam int TW   = $clog2(MAXT + 1) + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          ref_ack, hold, pending, stale, activity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  drs_timer #(.TW(TW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign activity = !ras_n || grant;

  drs_refresh_tick #(.INTERVAL(REF_INTERVAL), .IDLE_LIMIT(IDLE_LIMIT)) u_tick (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ref_en   (ref_en),
    .hold     (hold),
    .ack      (ref_ack),
    .activity (activity),
    .pending  (pending),
    .stale    (stale)
  );

  drs_fsm #(
    .TW(TW), .INIT_CYCLES(INIT_CYCLES), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_CAS_LEAD(T_CAS_LEAD), .T_SR(T_SR), .T_RPS(T_RPS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .host_req  (host_req),
    .host_done (host_done),
    .sr_req    (sr_req),
    .pending   (pending),
    .stale     (stale),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .ref_ack   (ref_ack),
    .hold      (hold),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .busy      (busy),
    .grant     (grant)
  );

  // R10: a pending refresh is never bypassed by a new grant
  a_r10_refresh_first: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pending && !busy && !grant) |=> !grant);

endmodule

// File: tb/dram_refresh_seq_bench.sv
module dram_refresh_seq_bench;
  localparam int P_PAUSE = 20;
  localparam int P_INIT  = 8;
  localparam int P_RAS   = 3;
  localparam int P_RP    = 2;
  localparam int P_LEAD  = 2;
  localparam int P_REF   = 50;
  localparam int P_IDLE  = 150;
  localparam int P_SR    = 6;
  localparam int P_RPS   = 4;

  logic clk, rst_n, ref_en, host_req, host_done, sr_req;
  logic ras_n, cas_n, busy, grant;
  int   n_run, n_fail, cyc;

  dram_refresh_seq #(
    .PAUSE_CYC(P_PAUSE), .INIT_CYCLES(P_INIT), .T_RAS(P_RAS), .T_RP(P_RP),
    .T_CAS_LEAD(P_LEAD), .REF_INTERVAL(P_REF), .IDLE_LIMIT(P_IDLE),
    .T_SR(P_SR), .T_RPS(P_RPS)
  ) u_dram_refresh_seq (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .host_req(host_req),
    .host_done(host_done), .sr_req(sr_req),
    .ras_n(ras_n), .cas_n(cas_n), .busy(busy), .grant(grant)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return ras_n;
      1: return cas_n;
      2: return busy;
      default: return grant;
    endcase
  endfunction

  // Number of falling-edge samples for which the signal keeps the level.
  task automatic run_len(input int sel, input logic lvl, input int limit, output int n);
    n = 0;
    while (sig(sel) == lvl && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_for(input int sel, input logic lvl, input int limit, output int n);
    n = 0;
    while (sig(sel) != lvl && n < limit) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Warm-up train: starts on the sample where ras_n is first low.
  task automatic check_warmup(input string tag);
    int n, bad_cas, bad_grant;
    bad_cas = 0; bad_grant = 0;
    for (int i = 0; i < P_INIT; i++) begin
      if (cas_n !== 1'b1) bad_cas++;
      if (grant !== 1'b0 || busy !== 1'b1) bad_grant++;
      run_len(0, 1'b0, 50, n);
      check({tag, " pulse width"}, n == P_RAS, n, P_RAS);
      if (i < P_INIT - 1) begin
        run_len(0, 1'b1, 50, n);
        check({tag, " gap"}, n == P_RP, n, P_RP);
      end else begin
        run_len(2, 1'b1, 50, n);
        check({tag, " last precharge"}, n == P_RP && ras_n && cas_n, n, P_RP);
      end
    end
    check({tag, " cas high, no grant"}, bad_cas == 0 && bad_grant == 0,
          bad_cas + bad_grant, 0);
  endtask

  task automatic release_bus();
    host_done = 1'b1; host_req = 1'b0;
    @(negedge clk);
    host_done = 1'b0;
  endtask

  task automatic t_reset_pause();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset levels", ras_n && cas_n && busy && !grant,
          {ras_n, cas_n, busy, grant}, 4'b1110);
    rst_n = 1'b1;
    host_req = 1'b1;   // must not be granted during pause
    run_len(0, 1'b1, 500, n);
    check("R1 pause length", n == P_PAUSE + 2, n, P_PAUSE + 2);
  endtask

  task automatic t_warmup();
    int n;
    check_warmup("R2");
    check("R2 busy low after warm-up", busy == 1'b0, busy, 0);
    @(negedge clk);
    check("R3 grant follows warm-up", grant == 1'b1, grant, 1);
  endtask

  task automatic t_host();
    int bad;
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      if (!(grant && ras_n && cas_n && !busy)) bad++;
      @(negedge clk);
    end
    check("R3 grant holds quiet bus", bad == 0, bad, 0);
    release_bus();
    check("R3 grant drops after done", grant == 1'b0, grant, 0);
  endtask

  task automatic t_stale();
    int n;
    wait_for(0, 1'b0, 400, n);
    check("R7 quiet limit", n >= P_IDLE - 1 && n <= P_IDLE + 3, n, P_IDLE + 1);
    host_req = 1'b1;
    check_warmup("R7");
    @(negedge clk);
    check("R7 grant after rerun", grant == 1'b1, grant, 1);
    release_bus();
  endtask

  task automatic check_cbr(input string tag);
    int n;
    check({tag, " cas first, busy"}, !cas_n && ras_n && busy, {cas_n, ras_n, busy}, 3'b011);
    run_len(0, 1'b1, 50, n);
    check({tag, " cas lead"}, n == P_LEAD, n, P_LEAD);
    check({tag, " both low"}, !cas_n, cas_n, 0);
    run_len(0, 1'b0, 50, n);
    check({tag, " ras width"}, n == P_RAS, n, P_RAS);
    check({tag, " both rise"}, cas_n && busy, {cas_n, busy}, 2'b11);
    run_len(2, 1'b1, 50, n);
    check({tag, " precharge"}, n == P_RP, n, P_RP);
  endtask

  task automatic t_refresh();
    int n, c0;
    ref_en = 1'b1;
    wait_for(1, 1'b0, 200, n);
    c0 = cyc;
    check_cbr("R4");
    wait_for(1, 1'b0, 200, n);
    check("R5 refresh spacing", cyc - c0 == P_REF, cyc - c0, P_REF);
    run_len(2, 1'b1, 50, n);
  endtask

  task automatic t_ref_off();
    int lows;
    lows = 0;
    ref_en = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (!cas_n || !ras_n) lows++;
      @(negedge clk);
    end
    check("R6 no refresh while off", lows == 0, lows, 0);
    ref_en = 1'b1;
  endtask

  task automatic t_priority();
    int n, bad;
    bad = 0;
    host_req = 1'b1;
    wait_for(3, 1'b1, 100, n);
    for (int i = 0; i < P_REF + 5; i++) begin
      if (!ras_n || !cas_n) bad++;
      @(negedge clk);
    end
    check("R10 refresh waits for access", bad == 0, bad, 0);
    host_done = 1'b1;   // request stays high
    @(negedge clk);
    host_done = 1'b0;
    n = 0;
    while (cas_n && !grant && n < 10) begin n++; @(negedge clk); end
    check("R10 refresh before new grant", !cas_n && !grant, {cas_n, grant}, 2'b00);
    check_cbr("R10");
    wait_for(3, 1'b1, 10, n);
    check("R10 grant after refresh", grant == 1'b1, grant, 1);
    release_bus();
  endtask

  task automatic t_sr_short();
    int n;
    sr_req = 1'b1;
    wait_for(1, 1'b0, 50, n);
    run_len(0, 1'b1, 50, n);
    check("R8 sr cas lead", n == P_LEAD && !cas_n, n, P_LEAD);
    sr_req = 1'b0;
    run_len(0, 1'b0, 50, n);
    check("R8 sr minimum hold", n == P_SR, n, P_SR);
    check("R9 exit strobes high", ras_n && cas_n, {ras_n, cas_n}, 2'b11);
    run_len(2, 1'b1, 50, n);
    check("R9 exit precharge", n == P_RPS, n, P_RPS);
    host_req = 1'b1;
    @(negedge clk);
    check("R9 immediate grant", grant == 1'b1, grant, 1);
    release_bus();
  endtask

  task automatic t_sr_long();
    int n, bad;
    bad = 0;
    sr_req = 1'b1;
    wait_for(1, 1'b0, 50, n);
    run_len(0, 1'b1, 50, n);
    for (int i = 0; i < 200; i++) begin
      if (ras_n || cas_n || !busy || grant) bad++;
      @(negedge clk);
    end
    check("R8 held while requested", bad == 0, bad, 0);
    sr_req = 1'b0;
    @(negedge clk);
    check("R9 long exit high", ras_n && cas_n && busy, {ras_n, cas_n, busy}, 3'b111);
    run_len(2, 1'b1, 50, n);
    check("R9 long exit precharge", n == P_RPS, n, P_RPS);
    wait_for(1, 1'b0, 200, n);
    check("R9 next refresh delay", n == P_REF + 1 && ras_n, n, P_REF + 1);
    check_cbr("R9");
  endtask

  initial begin
    n_run = 0; n_fail = 0; cyc = 0;
    rst_n = 1'b0; ref_en = 1'b0; host_req = 1'b0; host_done = 1'b0; sr_req = 1'b0;
    @(negedge clk);
    t_reset_pause();
    t_warmup();
    t_host();
    t_stale();
    t_refresh();
    t_ref_off();
    t_priority();
    t_sr_short();
    t_sr_long();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule